// File: doc/BRIEF.md
# Coded-Stream Carrier Sense Detector

This block watches a received line stream after descrambling. The stream is coded five bits per symbol and arrives one bit per clock, most significant bit of each symbol first. From it the block produces a registered carrier-sense flag. While no stream is present, the block looks at raw bits only. Receive carrier comes on as soon as two zeros with at least one other bit between them sit inside the most recent ten bits. Receive carrier goes off again if ten ones arrive in a row before a stream start is recognised.

A stream start is a J code group (11000) followed by a K code group (10001). The symbol boundary is fixed at the bit that completes J. From that point the block assembles five-bit symbols. It holds receive carrier until one of two pairs arrives: an end pair (T = 01101 then R = 00111) or two idles (11111 then 11111). Carrier falls one clock after the last bit of the confirming second symbol. If the first symbol of a pair is not followed by its partner, the pair is abandoned and carrier stays on.

The output is the receive carrier ORed with a transmit-activity input. A mode input selects full-duplex or repeater behaviour, and in that mode transmit activity is ignored.

Top module: `cs4b5b_carrier_detect`

## Requirements
- R1: While rst_n is low, crs is low on every clock, whatever rx_bit, tx_active and fdx_rpt are. After reset the block is in the unaligned search state with an all-ones history.
- R2: With no carrier, crs rises on the clock edge that samples the bit completing two zeros at least two bit positions apart within the last ten received bits. A lone zero, or two adjacent zeros with ones around them, does not raise crs. Two zeros ten positions apart do not raise crs either.
- R3: While carrier is on and no J (11000) has been aligned, the tenth consecutive one releases receive carrier at that clock edge. The bit history is then cleared to all ones.
- R4: A J code group (11000, MSB first) fixes the symbol boundary at its last bit. If the next five bits form K (10001), the block locks to the stream. The idle-then-J case raises carrier and starts alignment on the same bit.
- R5: If the five bits after J are not K, the block returns to the unaligned state with carrier still on. After that, R3 applies.
- R6: While locked, a run of ten or more ones does not release carrier unless it forms an idle pair on symbol boundaries.
- R7: While locked, T (01101) followed by R (00111) releases receive carrier at the edge that samples the last bit of R.
- R8: While locked, two consecutive IDLE symbols (11111) release receive carrier at the edge that samples the last bit of the second IDLE.
- R9: T followed by any symbol other than R, or IDLE followed by any symbol other than IDLE, keeps carrier on.
- R10: With fdx_rpt low, crs is the registered OR of the receive carrier and tx_active. With fdx_rpt high, tx_active has no effect on crs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Unscrambled coded receive bit, one per clock |
| tx_active | input | 1 | Transmit activity indication |
| fdx_rpt | input | 1 | High for full-duplex or repeater mode |
| crs | output | 1 | Registered carrier sense |

## Verification
Carrier activation by the zero-pair rule and J alignment can fall on the same sampled bit. This happens when an idle line is followed directly by J: the third zero of J both completes a non-adjacent zero pair and completes the J pattern. The bench provokes this with frames that start straight out of idle. It judges the case by whether the following K locks the stream and the frame's T/R pair later releases carrier on the exact clock the behavioural model predicts. A second collision is transmit activity arriving while receive carrier is falling. The bench covers it by changing tx_active and fdx_rpt in the middle of frames.

// File: rtl/cs4b5b_pkg.sv
`timescale 1ns/1ps
// Package: shared code groups and state types for the coded-stream carrier detector.
// Assumes 5-bit code groups shifted in MSB first.
package cs4b5b_pkg;
    localparam int SYM_W = 5;

    localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
    localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
    localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,   // no carrier, raw-bit watch
        ST_LOOSE  = 2'd1,   // carrier on, not aligned
        ST_WANT_K = 2'd2,   // J seen, expecting K
        ST_LOCKED = 2'd3    // aligned stream
    } cs_state_e;

    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_T    = 2'd1,
        PD_IDLE = 2'd2
    } cs_pend_e;
endpackage

// File: rtl/cs4b5b_bit_window.sv
`timescale 1ns/1ps
// Module: raw-bit history for activation, J pattern match and ones-run counting.
// Assumes the history is refilled with ones whenever clear is pulsed, so
// zeros from a finished stream cannot re-trigger carrier.
module cs4b5b_bit_window
    import cs4b5b_pkg::*;
#(
    parameter int WIN      = 10,
    parameter int ONES_RUN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic clear,
    output logic act_hit,
    output logic j_hit,
    output logic ones_hit
);
    localparam int OW = $clog2(ONES_RUN + 1);

    logic [WIN-1:0] hist_q;
    logic [WIN-1:0] win_n;
    logic [OW-1:0]  ones_q;

    assign win_n = {hist_q[WIN-2:0], bit_in};

    // Purpose: look for two zeros at least two positions apart in the window.
    always_comb begin
        act_hit = 1'b0;
        for (int i = 0; i < WIN - 2; i++) begin
            for (int j = i + 2; j < WIN; j++) begin
                if (!win_n[i] && !win_n[j]) act_hit = 1'b1;
            end
        end
    end

    assign j_hit    = (win_n[SYM_W-1:0] == CG_J);
    assign ones_hit = bit_in && (ones_q >= OW'(ONES_RUN - 1));

    // Purpose: keep bit history, refilled with ones on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hist_q <= '1;
        else                 hist_q <= win_n;
    end

    // Purpose: count consecutive ones, saturating below the release limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                    ones_q <= '0;
        else if (!bit_in)                       ones_q <= '0;
        else if (ones_q != OW'(ONES_RUN - 1))   ones_q <= ones_q + 1'b1;
    end
endmodule

// File: rtl/cs4b5b_sym_track.sv
`timescale 1ns/1ps
// Module: assembles 5-bit symbols on boundaries fixed by an align pulse.
// Assumes align is pulsed on the bit that completes J; the next bit is a symbol MSB.
module cs4b5b_sym_track
    import cs4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             align,
    input  logic             run,
    output logic             sym_done,
    output logic [SYM_W-1:0] sym_word
);
    localparam int CW = $clog2(SYM_W);

    logic [CW-1:0]    cnt_q;
    logic [SYM_W-1:0] sh_q;

    assign sym_word = {sh_q[SYM_W-2:0], bit_in};
    assign sym_done = run && !align && (cnt_q == CW'(SYM_W - 1));

    // Purpose: bit position within the current symbol.
    always_ff @(posedge clk) begin
        if (!rst_n || align)               cnt_q <= '0;
        else if (run) begin
            if (cnt_q == CW'(SYM_W - 1))   cnt_q <= '0;
            else                           cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: shift received bits into the symbol register.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sym_word;
    end
endmodule

// File: rtl/cs4b5b_rx_fsm.sv
`timescale 1ns/1ps
// Module: receive-carrier state machine (search, unaligned, wait-for-K, locked).
// Assumes its inputs are combinational views of the bit now being sampled.
module cs4b5b_rx_fsm
    import cs4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit,
    input  logic             j_hit,
    input  logic             ones_hit,
    input  logic             sym_done,
    input  logic [SYM_W-1:0] sym_word,
    output logic             rx_on,
    output logic             rx_on_n,
    output logic             align,
    output logic             run,
    output logic             clear
);
    cs_state_e st_q, st_n;
    cs_pend_e  pd_q, pd_n;

    assign run = (st_q == ST_WANT_K) || (st_q == ST_LOCKED);

    // Purpose: next-state, pending-pair and carrier decisions for the sampled bit.
    always_comb begin
        st_n    = st_q;
        pd_n    = pd_q;
        rx_on_n = rx_on;
        align   = 1'b0;
        clear   = 1'b0;
        unique case (st_q)
            ST_HUNT: begin
                if (act_hit) begin
                    rx_on_n = 1'b1;
                    if (j_hit) begin
                        st_n  = ST_WANT_K;
                        align = 1'b1;
                    end else begin
                        st_n = ST_LOOSE;
                    end
                end
            end
            ST_LOOSE: begin
                if (ones_hit) begin
                    rx_on_n = 1'b0;
                    st_n    = ST_HUNT;
                    clear   = 1'b1;
                end else if (j_hit) begin
                    st_n  = ST_WANT_K;
                    align = 1'b1;
                end
            end
            ST_WANT_K: begin
                if (sym_done) begin
                    pd_n = PD_NONE;
                    st_n = (sym_word == CG_K) ? ST_LOCKED : ST_LOOSE;
                end
            end
            ST_LOCKED: begin
                if (sym_done) begin
                    if ((pd_q == PD_T && sym_word == CG_R) ||
                        (pd_q == PD_IDLE && sym_word == CG_IDLE)) begin
                        rx_on_n = 1'b0;
                        st_n    = ST_HUNT;
                        clear   = 1'b1;
                        pd_n    = PD_NONE;
                    end else if (sym_word == CG_T) begin
                        pd_n = PD_T;
                    end else if (sym_word == CG_IDLE) begin
                        pd_n = PD_IDLE;
                    end else begin
                        pd_n = PD_NONE;
                    end
                end
            end
            default: st_n = ST_HUNT;
        endcase
    end

    // Purpose: state, pending-pair and receive-carrier registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            pd_q  <= PD_NONE;
            rx_on <= 1'b0;
        end else begin
            st_q  <= st_n;
            pd_q  <= pd_n;
            rx_on <= rx_on_n;
        end
    end
endmodule

// File: rtl/cs4b5b_carrier_detect.sv
`timescale 1ns/1ps
// Module: top of the coded-stream carrier detector; merges receive carrier
// with transmit activity according to the duplex/repeater mode.
// Assumes rx_bit is already descrambled and aligned to clk.
module cs4b5b_carrier_detect
    import cs4b5b_pkg::*;
#(
    parameter int WIN      = 10,
    parameter int ONES_RUN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic tx_active,
    input  logic fdx_rpt,
    output logic crs
);
    logic act_hit, j_hit, ones_hit;
    logic sym_done;
    logic [SYM_W-1:0] sym_word;
    logic rx_on, rx_on_n, align, run, clear;

    cs4b5b_bit_window #(.WIN(WIN), .ONES_RUN(ONES_RUN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .clear    (clear),
        .act_hit  (act_hit),
        .j_hit    (j_hit),
        .ones_hit (ones_hit)
    );

    cs4b5b_sym_track u_sym (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .align    (align),
        .run      (run),
        .sym_done (sym_done),
        .sym_word (sym_word)
    );

    cs4b5b_rx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_hit  (act_hit),
        .j_hit    (j_hit),
        .ones_hit (ones_hit),
        .sym_done (sym_done),
        .sym_word (sym_word),
        .rx_on    (rx_on),
        .rx_on_n  (rx_on_n),
        .align    (align),
        .run      (run),
        .clear    (clear)
    );

    // Purpose: registered carrier sense, transmit term masked in duplex/repeater mode.
    always_ff @(posedge clk) begin
        if (!rst_n) crs <= 1'b0;
        else        crs <= rx_on_n | (tx_active & ~fdx_rpt);
    end
endmodule

// File: rtl/cs4b5b_checker.sv
`timescale 1ns/1ps
// Module: property checker for the carrier detector, attached by bind.
module cs4b5b_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_bit,
    input logic tx_active,
    input logic fdx_rpt,
    input logic crs,
    input logic rx_on
);
    // R10: transmit activity forces carrier when not in duplex/repeater mode
    p_tx_forces_crs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !fdx_rpt) |=> crs);

    // R10: in duplex/repeater mode the output follows receive carrier only
    p_fdx_rx_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fdx_rpt |=> (crs == rx_on));

    // R2: receive carrier can only come on when a zero was sampled
    p_rise_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_on) |-> !$past(rx_bit));

    // R3: every release (ones run, R, or second IDLE) ends on a one
    p_fall_on_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_on) |-> $past(rx_bit));

    // R1: reset holds carrier low
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !crs);
endmodule

bind cs4b5b_carrier_detect cs4b5b_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_bit    (rx_bit),
    .tx_active (tx_active),
    .fdx_rpt   (fdx_rpt),
    .crs       (crs),
    .rx_on     (rx_on)
);

// File: tb/cs4b5b_carrier_detect_test.sv
`timescale 1ns/1ps
module cs4b5b_carrier_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1;
    logic tx_active = 1'b0;
    logic fdx_rpt = 1'b0;
    logic crs;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference model state
    bit hist[$];
    int m_st;      // 0 search, 1 unaligned on, 2 expecting K, 3 locked
    int m_ones;
    int m_cnt;
    int m_sym;
    int m_pend;    // 0 none, 1 after T, 2 after IDLE
    bit m_rx;
    bit m_crs;

    always #5 clk = ~clk;

    cs4b5b_carrier_detect uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .tx_active (tx_active),
        .fdx_rpt   (fdx_rpt),
        .crs       (crs)
    );

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < 10; i++) hist.push_back(1'b1);
        m_st = 0; m_ones = 0; m_cnt = 0; m_sym = 0; m_pend = 0;
        m_rx = 0; m_crs = 0;
    endtask

    task automatic model_step(input bit b, input bit tx, input bit md);
        bit act, jm, done, clr;
        int last5;
        hist.push_back(b);
        if (hist.size() > 10) void'(hist.pop_front());
        act = 0;
        for (int i = 0; i < hist.size(); i++)
            for (int j = i + 2; j < hist.size(); j++)
                if (hist[i] == 0 && hist[j] == 0) act = 1;
        last5 = 0;
        for (int i = hist.size() - 5; i < hist.size(); i++) last5 = (last5 << 1) | hist[i];
        jm = (last5 == 5'b11000);
        m_ones = b ? m_ones + 1 : 0;
        done = 0;
        if (m_st == 2 || m_st == 3) begin
            m_sym = ((m_sym << 1) | b) & 31;
            m_cnt++;
            if (m_cnt == 5) begin done = 1; m_cnt = 0; end
        end
        clr = 0;
        case (m_st)
            0: if (act) begin
                   m_rx = 1;
                   if (jm) begin m_st = 2; m_cnt = 0; end else m_st = 1;
               end
            1: if (m_ones >= 10) begin m_rx = 0; m_st = 0; clr = 1; end
               else if (jm) begin m_st = 2; m_cnt = 0; end
            2: if (done) begin m_pend = 0; m_st = (m_sym == 5'b10001) ? 3 : 1; end
            default: if (done) begin
                   if ((m_pend == 1 && m_sym == 5'b00111) || (m_pend == 2 && m_sym == 31)) begin
                       m_rx = 0; m_st = 0; clr = 1; m_pend = 0;
                   end else if (m_sym == 5'b01101) m_pend = 1;
                   else if (m_sym == 31) m_pend = 2;
                   else m_pend = 0;
               end
        endcase
        if (clr) begin
            hist.delete();
            for (int i = 0; i < 10; i++) hist.push_back(1'b1);
            m_ones = 0;
        end
        m_crs = m_rx | (tx & !md);
    endtask

    task automatic check(input string tag);
        checks++;
        if (crs !== m_crs) begin
            errors++;
            $display("FAIL %s at %0t: crs actual=%0b expected=%0b", tag, $time, crs, m_crs);
        end
    endtask

    task automatic step(input bit b, input string tag);
        rx_bit = b;
        @(posedge clk);
        model_step(b, tx_active, fdx_rpt);
        #1;
        check(tag);
    endtask

    task automatic send_sym(input logic [4:0] v, input string tag);
        for (int i = 4; i >= 0; i--) step(v[i], tag);
    endtask

    task automatic ones(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, tag);
    endtask

    initial begin
        model_reset();
        // R1: reset dominates inputs
        tx_active = 1'b1;
        rx_bit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check("R1");
        end
        tx_active = 1'b0;
        rx_bit = 1'b1;
        rst_n = 1'b1;
        ones(12, "R1");

        // R2: patterns that must not activate
        step(1'b0, "R2"); ones(12, "R2");
        step(1'b0, "R2"); step(1'b0, "R2"); ones(12, "R2");
        step(1'b0, "R2"); ones(9, "R2"); step(1'b0, "R2"); ones(12, "R2");
        // R2: activating pair, then R3 release after ten ones
        step(1'b0, "R2"); step(1'b1, "R2"); step(1'b0, "R2");
        ones(12, "R3");
        // R2: zeros nine apart activate
        step(1'b0, "R2"); ones(8, "R2"); step(1'b0, "R2");
        ones(12, "R3");

        // R4/R7: idle straight into J (activation and alignment on one bit), T R release
        send_sym(5'b11000, "R4"); send_sym(5'b10001, "R4");
        send_sym(5'b10101, "R6"); send_sym(5'b01110, "R6");
        send_sym(5'b01101, "R7"); send_sym(5'b00111, "R7");
        ones(15, "R7");

        // R6/R9: long ones run in-stream, broken pairs, then IDLE IDLE release (R8)
        send_sym(5'b11000, "R4"); send_sym(5'b10001, "R4");
        send_sym(5'b01111, "R6"); send_sym(5'b11111, "R6"); send_sym(5'b11110, "R6");
        send_sym(5'b01101, "R9"); send_sym(5'b10110, "R9");
        send_sym(5'b11111, "R9"); send_sym(5'b01011, "R9");
        send_sym(5'b01101, "R9"); send_sym(5'b01101, "R9"); send_sym(5'b11111, "R9");
        send_sym(5'b11111, "R8");
        ones(15, "R8");

        // R5: J then non-K, then unaligned release by ones
        send_sym(5'b11000, "R5"); send_sym(5'b10101, "R5");
        ones(12, "R5");

        // R10: transmit activity in half-duplex mode and in duplex mode
        tx_active = 1'b1;
        ones(4, "R10");
        fdx_rpt = 1'b1;
        ones(4, "R10");
        send_sym(5'b11000, "R10"); send_sym(5'b10001, "R10");
        send_sym(5'b01101, "R10");
        fdx_rpt = 1'b0;
        send_sym(5'b00111, "R10");
        tx_active = 1'b0;
        ones(6, "R10");
        fdx_rpt = 1'b1;
        tx_active = 1'b1;
        send_sym(5'b11000, "R10"); send_sym(5'b10001, "R10");
        send_sym(5'b11111, "R10"); send_sym(5'b11111, "R10");
        ones(6, "R10");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule